// File: doc/BRIEF.md
# FIFO Watermark Request Logic

This block holds a transmit queue and a receive queue of data words and produces the transfer-request and status signals that a serial controller gives to its processor and its DMA channels. The transmit queue is filled from the bus side and drained by the serial engine. The receive queue is filled by the serial engine and drained from the bus side. Each direction has a programmable 3-bit watermark code. The transmit code sets how many free stages must exist before more data is requested. The receive code sets how many valid entries must exist before a read is requested.

Overflow and underflow on either queue are recorded as sticky error bits, and software clears them by writing a one. Every status bit has its own interrupt enable. Each request can be sent to a DMA request line instead of the interrupt. DMA operation typically uses watermark code 7 for transmit and code 0 for receive, so that a request is raised whenever a single stage is free or a single entry is valid.

Top module: `fifo_wm_req`

## Requirements
- R1: Transmit code (control bits 31:29) maps 0..7 to 64, 32, 24, 16, 12, 8, 4, 1 free stages. Status bit 1 (transmit request) is high when the number of free stages is at least that threshold.
- R2: Receive code (control bits 15:13) maps 0..7 to 1, 4, 8, 16, 32, 64, 128, 256 valid entries. Status bit 5 (receive request) is high when the number of valid entries is at least that threshold.
- R3: A threshold larger than the queue depth is replaced by the depth.
- R4: Each queue returns words in the order they were written. Read data is presented in the same cycle as the pop, and push and pop may occur in the same cycle.
- R5: A push while the queue holds depth entries at the start of the cycle is dropped, and the overflow bit is set. This is status bit 2 for transmit and bit 6 for receive.
- R6: A pop from an empty queue returns zero and sets the underflow bit. This is status bit 3 for transmit and bit 7 for receive.
- R7: Error bits stay set until a one is written to the same bit of the clear input. A new error in the same cycle as the clear keeps the bit set. Clear bits in positions 0, 1, 4 and 5 have no effect.
- R8: Status bit 0 is high while the transmit queue is empty. Status bit 4 is high while the receive queue holds depth entries.
- R9: The irq output is high when any status bit with its enable set is high. A request bit whose DMA enable is set does not contribute to irq.
- R10: tx_dreq equals transmit request AND tx_dma_en. rx_dreq equals receive request AND rx_dma_en.
- R11: After reset both queues are empty, all error bits are clear, and irq and both DMA requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_ctl | input | 32 | Control word holding both watermark codes |
| tx_wr | input | 1 | Push into the transmit queue |
| tx_wdata | input | DATA_W | Transmit push data |
| tx_rd | input | 1 | Pop from the transmit queue (serial side) |
| tx_rdata | output | DATA_W | Transmit head word, zero when empty |
| rx_wr | input | 1 | Push into the receive queue (serial side) |
| rx_wdata | input | DATA_W | Receive push data |
| rx_rd | input | 1 | Pop from the receive queue |
| rx_rdata | output | DATA_W | Receive head word, zero when empty |
| irq_en | input | 8 | Per-bit interrupt enables |
| tx_dma_en | input | 1 | Route the transmit request to tx_dreq |
| rx_dma_en | input | 1 | Route the receive request to rx_dreq |
| status_w1c | input | 8 | Write-one-to-clear strobes for the error bits |
| status | output | 8 | {rx_udf, rx_ovf, rx_req, rx_full, tx_udf, tx_ovf, tx_req, tx_empty} |
| irq | output | 1 | Interrupt request |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |

## Verification
The checker assumes that push, pop and clear strobes are single-cycle levels, sampled at the rising edge and held steady around it. It also assumes that the internal counts never pass the depth, so an overflow assertion can key off a full count. The bench changes every input one nanosecond after a rising edge and samples outputs one nanosecond later. This keeps each strobe stable across exactly one capturing edge. The bench fills each queue only through its push port. It therefore never creates a state the checker could not reach from reset.

// File: rtl/fifo_wm_req.sv
module fifo_wm_req #(
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       fifo_ctl,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_rd,
  output logic [DATA_W-1:0] tx_rdata,
  input  logic              rx_wr,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic [7:0]        irq_en,
  input  logic              tx_dma_en,
  input  logic              rx_dma_en,
  input  logic [7:0]        status_w1c,
  output logic [7:0]        status,
  output logic              irq,
  output logic              tx_dreq,
  output logic              rx_dreq
);

  localparam int TXP_W = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int RXP_W = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int TXC_W = $clog2(TX_DEPTH + 1);
  localparam int RXC_W = $clog2(RX_DEPTH + 1);
  localparam logic [31:0] TXD32 = 32'(TX_DEPTH);
  localparam logic [31:0] RXD32 = 32'(RX_DEPTH);

  function automatic logic [31:0] tx_stages(input logic [2:0] code);
    case (code)
      3'd0:    return 32'd64;
      3'd1:    return 32'd32;
      3'd2:    return 32'd24;
      3'd3:    return 32'd16;
      3'd4:    return 32'd12;
      3'd5:    return 32'd8;
      3'd6:    return 32'd4;
      default: return 32'd1;
    endcase
  endfunction

  function automatic logic [31:0] rx_stages(input logic [2:0] code);
    return 32'd1 << ((code == 3'd0) ? 0 : (32'(code) * 1 + 1));
  endfunction

  logic [DATA_W-1:0] tx_mem [TX_DEPTH];
  logic [DATA_W-1:0] rx_mem [RX_DEPTH];
  logic [TXP_W-1:0]  tx_wp, tx_rp;
  logic [RXP_W-1:0]  rx_wp, rx_rp;
  logic [TXC_W-1:0]  tx_cnt;
  logic [RXC_W-1:0]  rx_cnt;
  logic              tx_ovf, tx_udf, rx_ovf, rx_udf;

  wire tx_empty = (tx_cnt == '0);
  wire tx_full  = (tx_cnt == TXC_W'(TX_DEPTH));
  wire rx_empty = (rx_cnt == '0);
  wire rx_full  = (rx_cnt == RXC_W'(RX_DEPTH));
  wire tx_push  = tx_wr & ~tx_full;
  wire tx_pop   = tx_rd & ~tx_empty;
  wire rx_push  = rx_wr & ~rx_full;
  wire rx_pop   = rx_rd & ~rx_empty;

  wire [31:0] tx_raw = tx_stages(fifo_ctl[31:29]);
  wire [31:0] rx_raw = rx_stages(fifo_ctl[15:13]);
  wire [31:0] tx_thr = (tx_raw > TXD32) ? TXD32 : tx_raw;
  wire [31:0] rx_thr = (rx_raw > RXD32) ? RXD32 : rx_raw;
  wire        tx_req = (TXD32 - 32'(tx_cnt)) >= tx_thr;
  wire        rx_req = 32'(rx_cnt) >= rx_thr;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == TXP_W'(TX_DEPTH - 1)) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == TXP_W'(TX_DEPTH - 1)) ? '0 : tx_rp + 1'b1;
      if (tx_push && !tx_pop)      tx_cnt <= tx_cnt + 1'b1;
      else if (!tx_push && tx_pop) tx_cnt <= tx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= (rx_wp == RXP_W'(RX_DEPTH - 1)) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == RXP_W'(RX_DEPTH - 1)) ? '0 : rx_rp + 1'b1;
      if (rx_push && !rx_pop)      rx_cnt <= rx_cnt + 1'b1;
      else if (!rx_push && rx_pop) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0;
      tx_udf <= 1'b0;
      rx_ovf <= 1'b0;
      rx_udf <= 1'b0;
    end else begin
      tx_ovf <= (tx_wr & tx_full)  | (tx_ovf & ~status_w1c[2]);
      tx_udf <= (tx_rd & tx_empty) | (tx_udf & ~status_w1c[3]);
      rx_ovf <= (rx_wr & rx_full)  | (rx_ovf & ~status_w1c[6]);
      rx_udf <= (rx_rd & rx_empty) | (rx_udf & ~status_w1c[7]);
    end
  end

  assign tx_rdata = tx_empty ? '0 : tx_mem[tx_rp];
  assign rx_rdata = rx_empty ? '0 : rx_mem[rx_rp];
  assign status   = {rx_udf, rx_ovf, rx_req, rx_full, tx_udf, tx_ovf, tx_req, tx_empty};
  assign irq      = |(status & irq_en & ~{2'b00, rx_dma_en, 3'b000, tx_dma_en, 1'b0});
  assign tx_dreq  = tx_dma_en & tx_req;
  assign rx_dreq  = rx_dma_en & rx_req;

endmodule

// File: rtl/fifo_wm_req_chk.sv
module fifo_wm_req_chk #(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 256
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tx_wr,
  input logic                         rx_wr,
  input logic                         rx_rd,
  input logic                         tx_dma_en,
  input logic                         tx_dreq,
  input logic [7:0]                   status,
  input logic [7:0]                   status_w1c,
  input logic [$clog2(TX_DEPTH+1)-1:0] tx_cnt,
  input logic [$clog2(RX_DEPTH+1)-1:0] rx_cnt
);

  localparam int TXC_W = $clog2(TX_DEPTH + 1);
  localparam int RXC_W = $clog2(RX_DEPTH + 1);

  p_tx_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_cnt == TXC_W'(TX_DEPTH)) |=> status[2]);

  p_rx_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr && !rx_rd && status[4]) |=> ($stable(rx_cnt) && status[6]));

  p_rx_udf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_cnt == '0) |=> status[7]);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !status_w1c[2]) |=> status[2]);

  p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= TXC_W'(TX_DEPTH)) && (rx_cnt <= RXC_W'(RX_DEPTH)));

  p_dreq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq |-> (status[1] && tx_dma_en));

endmodule

bind fifo_wm_req fifo_wm_req_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .rx_wr(rx_wr), .rx_rd(rx_rd),
  .tx_dma_en(tx_dma_en), .tx_dreq(tx_dreq), .status(status),
  .status_w1c(status_w1c), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_fifo_wm_req.sv
`timescale 1ns/1ps
module test_fifo_wm_req;
  localparam int TXD = 16;
  localparam int RXD = 32;
  localparam int NV  = 11;
  // {tx fill, rx fill, tx code, rx code, exp tx_req, exp rx_req}
  localparam int VEC [NV][6] = '{
    '{0, 0, 0, 0, 1, 0}, '{1, 1, 0, 0, 0, 1}, '{4, 3, 4, 1, 1, 0},
    '{5, 4, 4, 1, 0, 1}, '{8, 8, 5, 2, 1, 1}, '{9, 15, 5, 3, 0, 0},
    '{12, 16, 6, 3, 1, 1}, '{15, 31, 7, 4, 1, 0}, '{16, 32, 7, 7, 0, 1},
    '{0, 32, 2, 5, 1, 1}, '{13, 20, 6, 2, 0, 1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] fifo_ctl = '0, tx_wdata = '0, rx_wdata = '0;
  logic tx_wr = 0, tx_rd = 0, rx_wr = 0, rx_rd = 0, tx_dma_en = 0, rx_dma_en = 0;
  logic [7:0] irq_en = '0, status_w1c = '0;
  logic [31:0] tx_rdata, rx_rdata;
  logic [7:0] status;
  logic irq, tx_dreq, rx_dreq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] txq[$], rxq[$];
  logic [31:0] seq = 32'h1000;

  always #2.5 clk = ~clk;

  fifo_wm_req #(.DATA_W(32), .TX_DEPTH(TXD), .RX_DEPTH(RXD)) i_fifo_wm_req (
    .clk(clk), .rst_n(rst_n), .fifo_ctl(fifo_ctl),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_rd(tx_rd), .tx_rdata(tx_rdata),
    .rx_wr(rx_wr), .rx_wdata(rx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .irq_en(irq_en), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .status_w1c(status_w1c), .status(status), .irq(irq),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic tw, input logic [31:0] twd, input logic tr,
                     input logic rw, input logic [31:0] rwd, input logic rr,
                     input logic [7:0] clr);
    logic [31:0] e;
    tx_wr = tw; tx_wdata = twd; tx_rd = tr;
    rx_wr = rw; rx_wdata = rwd; rx_rd = rr; status_w1c = clr;
    #1;
    if (tr) begin
      e = (txq.size() > 0) ? txq[0] : 32'h0;
      chk(txq.size() > 0 ? "R4 tx pop order" : "R6 tx empty pop zero", tx_rdata, e);
    end
    if (rr) begin
      e = (rxq.size() > 0) ? rxq[0] : 32'h0;
      chk(rxq.size() > 0 ? "R4 rx pop order" : "R6 rx empty pop zero", rx_rdata, e);
    end
    begin
      bit tfull = (txq.size() == TXD), rfull = (rxq.size() == RXD);
      bit tnon = (txq.size() > 0), rnon = (rxq.size() > 0);
      if (tr && tnon) void'(txq.pop_front());
      if (rr && rnon) void'(rxq.pop_front());
      if (tw && !tfull) txq.push_back(twd);
      if (rw && !rfull) rxq.push_back(rwd);
    end
    @(posedge clk); #1;
    tx_wr = 0; tx_rd = 0; rx_wr = 0; rx_rd = 0; status_w1c = '0;
  endtask

  task automatic set_fill(input int tt, input int rt);
    while (txq.size() < tt) begin seq++; cyc(1, seq, 0, 0, 0, 0, 8'h00); end
    while (txq.size() > tt) cyc(0, 0, 1, 0, 0, 0, 8'h00);
    while (rxq.size() < rt) begin seq++; cyc(0, 0, 0, 1, seq ^ 32'hA5A5_0000, 0, 8'h00); end
    while (rxq.size() > rt) cyc(0, 0, 0, 0, 0, 1, 8'h00);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R11 reset state: tx empty and tx request (code 0 clamps to 16) only
    chk("R11 status after reset", {24'h0, status}, 32'h03);
    chk("R11 irq/dreq after reset", {29'h0, irq, tx_dreq, rx_dreq}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      fifo_ctl = (32'(VEC[v][2]) << 29) | (32'(VEC[v][3]) << 13);
      set_fill(VEC[v][0], VEC[v][1]);
      #1;
      chk($sformatf("R1 tx_req vector %0d", v), {31'h0, status[1]}, 32'(VEC[v][4]));
      chk($sformatf("R2 rx_req vector %0d", v), {31'h0, status[5]}, 32'(VEC[v][5]));
    end

    // R3: tx code 2 (24) clamps to 16, rx code 6 (128) clamps to 32
    fifo_ctl = (32'd2 << 29) | (32'd6 << 13);
    set_fill(1, 31); #1;
    chk("R3 tx clamp one used", {31'h0, status[1]}, 32'h0);
    chk("R3 rx clamp one short", {31'h0, status[5]}, 32'h0);
    set_fill(0, 32); #1;
    chk("R3 tx clamp empty", {31'h0, status[1]}, 32'h1);
    chk("R3 rx clamp full", {31'h0, status[5]}, 32'h1);
    chk("R8 rx full bit", {31'h0, status[4]}, 32'h1);
    chk("R8 tx empty bit", {31'h0, status[0]}, 32'h1);

    // R5 overflow on both queues
    fifo_ctl = '0;
    set_fill(TXD, RXD);
    cyc(1, 32'hDEAD_BEEF, 0, 1, 32'hBAD0_0BAD, 0, 8'h00);
    chk("R5 tx overflow bit", {31'h0, status[2]}, 32'h1);
    chk("R5 rx overflow bit", {31'h0, status[6]}, 32'h1);
    chk("R8 tx not empty", {31'h0, status[0]}, 32'h0);
    set_fill(0, 0);
    chk("R7 overflow sticky", {30'h0, status[6], status[2]}, 32'h3);
    cyc(0, 0, 0, 0, 0, 0, 8'h04);
    chk("R7 tx overflow cleared", {30'h0, status[6], status[2]}, 32'h2);
    set_fill(TXD, 0);
    cyc(1, 32'h1234_5678, 0, 0, 0, 0, 8'h44);
    chk("R7 set wins over clear", {30'h0, status[6], status[2]}, 32'h1);
    cyc(0, 0, 0, 0, 0, 0, 8'h44);
    chk("R7 both overflow cleared", {30'h0, status[6], status[2]}, 32'h0);

    // R6 underflow
    set_fill(0, 0);
    cyc(0, 0, 1, 0, 0, 1, 8'h00);
    chk("R6 underflow bits", {30'h0, status[7], status[3]}, 32'h3);
    cyc(0, 0, 0, 0, 0, 0, 8'h33);
    chk("R7 non-error clear ignored", {24'h0, status & 8'h89}, 32'h89);
    cyc(0, 0, 0, 0, 0, 0, 8'hCC);
    chk("R7 all errors cleared", {24'h0, status & 8'hCC}, 32'h0);

    // R9 / R10 routing: tx code 7 and rx code 0 are single-stage
    fifo_ctl = (32'd7 << 29);
    irq_en = 8'h02; #1;
    chk("R9 irq from tx request", {31'h0, irq}, 32'h1);
    tx_dma_en = 1; #1;
    chk("R9 tx request masked by dma", {31'h0, irq}, 32'h0);
    chk("R10 tx dreq", {31'h0, tx_dreq}, 32'h1);
    set_fill(TXD, 1); #1;
    chk("R10 tx dreq low when full", {31'h0, tx_dreq}, 32'h0);
    irq_en = 8'h20; rx_dma_en = 1; #1;
    chk("R10 rx dreq", {31'h0, rx_dreq}, 32'h1);
    chk("R9 rx request masked by dma", {31'h0, irq}, 32'h0);
    rx_dma_en = 0; #1;
    chk("R9 irq from rx request", {31'h0, irq}, 32'h1);
    chk("R10 rx dreq off", {31'h0, rx_dreq}, 32'h0);
    irq_en = 8'h04; #1;
    chk("R9 no error no irq", {31'h0, irq}, 32'h0);
    cyc(1, 32'h5555_AAAA, 0, 0, 0, 0, 8'h00);
    chk("R9 irq from overflow", {31'h0, irq}, 32'h1);
    // simultaneous push and pop at one entry keeps order
    set_fill(1, 1);
    seq++; cyc(1, seq, 1, 1, seq, 1, 8'h00);
    set_fill(0, 0);
    chk("R4 queues drained", {30'h0, status[4], status[0]}, 32'h1);

    finish_run();
  end
endmodule